// File: doc/BRIEF.md
# Pipelined Burst SRAM Core

This block is a synchronous static memory model built from registers. Each word is 36 bits wide and is split into four 9-bit byte lanes. Lane `i` occupies bits `9i+8:9i`, with bit `9i+8` as that lane's parity bit. On every clock edge the block captures the address, the write data, the three chip selects and the write enables. It then finishes the access on the following edge. A write is committed self-timed to the array. A read loads the output register, so read data appears one edge after the address was taken.

A single global write strobe writes a whole word. Otherwise, a byte-write strobe combined with four per-lane strobes picks the lanes to write. Three chip selects allow several banks to share one data bus. A bank drives the bus only after a selected read has gone through both pipeline stages. A bank releases the bus right after a deselect cycle is captured, so two banks never overlap on the bus. An output enable and a sleep input both force the outputs into the released state without waiting for a clock edge. Sleep also blocks every array access. The address sequence is supplied from outside the block.

Top module: `pbsram_core`

## Requirements
- R1: While `rst` is high at a clock edge, the pipeline is cleared. After that edge `dout_hiz` is 1 and `dout` is all zeros.
- R2: A cycle with `wr_all_n` low writes all four lanes of the addressed word from `din`, whatever `lane_wr_n` and `lane_sel_n` hold.
- R3: With `wr_all_n` high, lane `i` (bits `9i+8:9i`) is written only when `lane_wr_n` is low and `lane_sel_n[i]` is low. Lanes not enabled keep their old contents. A cycle that writes no lane is a read.
- R4: A selected read whose address is captured at edge k shows that word on `dout` after edge k+1 and keeps it until the next edge.
- R5: The block is selected only when `sel0_n`=0, `sel1`=1 and `sel2_n`=0. Any other combination performs neither a write nor a read.
- R6: Once a deselect cycle has been captured at an edge, `dout_hiz` is 1 right after that edge. This holds even if a read captured one edge earlier is due to be shown.
- R7: `out_en_n` high forces `dout_hiz` to 1 and `dout` to zero at once, with no clock edge needed. Lowering it shows the held read data again.
- R8: While `sleep` is high, no write or read happens at any edge, and `dout_hiz` is 1 at once.
- R9: A write to an address followed in the very next cycle by a read of that address returns the newly written word.
- R10: After the edge that completes a write, the outputs are released (`dout_hiz`=1). `dout_hiz` is 1 whenever `dout` is forced to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | AW | Word address |
| din | input | 36 | Write data, four 9-bit lanes |
| sel0_n | input | 1 | Chip select, active low |
| sel1 | input | 1 | Chip select, active high |
| sel2_n | input | 1 | Chip select, active low |
| wr_all_n | input | 1 | Global full-word write, active low |
| lane_wr_n | input | 1 | Byte-write enable, active low |
| lane_sel_n | input | 4 | Per-lane write enables, active low |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Power-down, blocks all access |
| dout | output | 36 | Read data, zero when released |
| dout_hiz | output | 1 | High-impedance flag for the output drivers |

## Verification
On a single edge, the block commits the write captured one edge earlier while it captures a read of the same word. The bench provokes this by issuing a write and then, in the next cycle, a read of the same address. It judges the case by comparing the returned word with the constant it wrote. A second case shows output release competing with data delivery. A read followed directly by a deselect must never show its data. A behavioural model with a byte-masked array predicts both the flag and the data on every clock, and it also covers random mixes of reads, writes, deselects, output-enable changes and sleep.

// File: rtl/pbsram_pkg.sv
package pbsram_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = 9;
  localparam int WORD_W = LANES * LANE_W;

  typedef struct packed {
    logic             sel;
    logic [LANES-1:0] wmask;
  } cyc_t;

  function automatic logic [LANES-1:0] lane_mask(
    input logic             wr_all_n,
    input logic             lane_wr_n,
    input logic [LANES-1:0] lane_sel_n
  );
    if (!wr_all_n)       return '1;
    else if (!lane_wr_n) return ~lane_sel_n;
    else                 return '0;
  endfunction
endpackage

// File: rtl/pbsram_in_reg.sv
module pbsram_in_reg
  import pbsram_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sleep,
  input  logic [AW-1:0]     addr,
  input  logic [WORD_W-1:0] din,
  input  logic              sel0_n,
  input  logic              sel1,
  input  logic              sel2_n,
  input  logic              wr_all_n,
  input  logic              lane_wr_n,
  input  logic [LANES-1:0]  lane_sel_n,
  output cyc_t              cyc_q,
  output logic [AW-1:0]     addr_q,
  output logic [WORD_W-1:0] din_q
);
  logic hit;
  assign hit = !sel0_n && sel1 && !sel2_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      cyc_q <= '0;
    end else begin
      cyc_q.sel   <= hit && !sleep;
      cyc_q.wmask <= lane_mask(wr_all_n, lane_wr_n, lane_sel_n);
    end
    addr_q <= addr;
    din_q  <= din;
  end
endmodule

// File: rtl/pbsram_array.sv
module pbsram_array
  import pbsram_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic [LANES-1:0]  we,
  input  logic              re,
  input  logic [AW-1:0]     addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] rd_q;

    always_ff @(posedge clk) begin
      if (we[g]) mem[addr] <= wdata[g*LANE_W +: LANE_W];
      if (re)    rd_q      <= mem[addr];
    end

    assign rdata[g*LANE_W +: LANE_W] = rd_q;
  end
endmodule

// File: rtl/pbsram_out_stage.sv
module pbsram_out_stage
  import pbsram_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              sleep,
  input  logic              out_en_n,
  input  logic              sel_q,
  input  logic              rd_en,
  input  logic [WORD_W-1:0] rdata,
  output logic [WORD_W-1:0] dout,
  output logic              dout_hiz
);
  logic drive_q;

  always_ff @(posedge clk) begin
    if (rst) drive_q <= 1'b0;
    else     drive_q <= rd_en;
  end

  assign dout_hiz = out_en_n || sleep || !drive_q || !sel_q;
  assign dout     = dout_hiz ? '0 : rdata;
endmodule

// File: rtl/pbsram_core.sv
module pbsram_core
  import pbsram_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [AW-1:0]     addr,
  input  logic [WORD_W-1:0] din,
  input  logic              sel0_n,
  input  logic              sel1,
  input  logic              sel2_n,
  input  logic              wr_all_n,
  input  logic              lane_wr_n,
  input  logic [LANES-1:0]  lane_sel_n,
  input  logic              out_en_n,
  input  logic              sleep,
  output logic [WORD_W-1:0] dout,
  output logic              dout_hiz
);
  cyc_t              cyc_q;
  logic [AW-1:0]     addr_q;
  logic [WORD_W-1:0] din_q;
  logic [WORD_W-1:0] rdata;
  logic [LANES-1:0]  we;
  logic              rd_en;
  logic              live;

  pbsram_in_reg #(.AW(AW)) u_in (
    .clk(clk), .rst(rst), .sleep(sleep), .addr(addr), .din(din),
    .sel0_n(sel0_n), .sel1(sel1), .sel2_n(sel2_n),
    .wr_all_n(wr_all_n), .lane_wr_n(lane_wr_n), .lane_sel_n(lane_sel_n),
    .cyc_q(cyc_q), .addr_q(addr_q), .din_q(din_q)
  );

  // Second stage: commit a write or load the output register.
  assign live  = cyc_q.sel && !sleep;
  assign we    = live ? cyc_q.wmask : '0;
  assign rd_en = live && (cyc_q.wmask == '0);

  pbsram_array #(.DEPTH(DEPTH), .AW(AW)) u_mem (
    .clk(clk), .we(we), .re(rd_en), .addr(addr_q),
    .wdata(din_q), .rdata(rdata)
  );

  pbsram_out_stage u_out (
    .clk(clk), .rst(rst), .sleep(sleep), .out_en_n(out_en_n),
    .sel_q(cyc_q.sel), .rd_en(rd_en), .rdata(rdata),
    .dout(dout), .dout_hiz(dout_hiz)
  );
endmodule

// File: rtl/pbsram_checker.sv
module pbsram_checker
  import pbsram_pkg::*;
#(
  parameter int AW = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [AW-1:0]     addr,
  input logic [WORD_W-1:0] din,
  input logic              sel0_n,
  input logic              sel1,
  input logic              sel2_n,
  input logic              wr_all_n,
  input logic              lane_wr_n,
  input logic [LANES-1:0]  lane_sel_n,
  input logic              out_en_n,
  input logic              sleep,
  input logic [WORD_W-1:0] dout,
  input logic              dout_hiz
);
  logic sel_in, any_wr;
  assign sel_in = !sel0_n && sel1 && !sel2_n;
  assign any_wr = !wr_all_n || (!lane_wr_n && !(&lane_sel_n));

  AST_RESET_RELEASE: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> dout_hiz); // R1
  AST_DESEL_RELEASE: assert property (@(posedge clk) disable iff (rst)
    !$past(sel_in) |-> dout_hiz); // R6
  AST_OE_RELEASE: assert property (@(posedge clk) disable iff (rst)
    out_en_n |-> dout_hiz); // R7
  AST_SLEEP_RELEASE: assert property (@(posedge clk) disable iff (rst)
    sleep |-> dout_hiz); // R8
  AST_WRITE_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
    $past(sel_in && any_wr, 2) |-> dout_hiz); // R10
  AST_ZERO_WHEN_Z: assert property (@(posedge clk) disable iff (rst)
    dout_hiz |-> (dout == '0)); // R10
endmodule

bind pbsram_core pbsram_checker #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .addr(addr), .din(din),
  .sel0_n(sel0_n), .sel1(sel1), .sel2_n(sel2_n),
  .wr_all_n(wr_all_n), .lane_wr_n(lane_wr_n), .lane_sel_n(lane_sel_n),
  .out_en_n(out_en_n), .sleep(sleep), .dout(dout), .dout_hiz(dout_hiz)
);

// File: tb/pbsram_core_bench.sv
module pbsram_core_bench;
  localparam int DEPTH = 16;
  localparam int AW    = 4;
  localparam int W     = 36;
  localparam logic [2:0] SEL = 3'b010;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [W-1:0]  din = '0;
  logic          sel0_n = 1'b1, sel1 = 1'b0, sel2_n = 1'b1;
  logic          wr_all_n = 1'b1, lane_wr_n = 1'b1;
  logic [3:0]    lane_sel_n = 4'hF;
  logic          out_en_n = 1'b0, sleep = 1'b0;
  logic [W-1:0]  dout;
  logic          dout_hiz;

  pbsram_core #(.DEPTH(DEPTH), .AW(AW)) u_pbsram_core (
    .clk(clk), .rst(rst), .addr(addr), .din(din),
    .sel0_n(sel0_n), .sel1(sel1), .sel2_n(sel2_n),
    .wr_all_n(wr_all_n), .lane_wr_n(lane_wr_n), .lane_sel_n(lane_sel_n),
    .out_en_n(out_en_n), .sleep(sleep), .dout(dout), .dout_hiz(dout_hiz)
  );

  int    errors = 0, checks = 0;
  string tag = "R1";
  logic [W-1:0] ref_mem [DEPTH];
  bit            m_sel = 0, m_drv = 0;
  logic [3:0]    m_mask = '0;
  logic [AW-1:0] m_addr = '0;
  logic [W-1:0]  m_din = '0, m_dat = '0;

  task automatic check(input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] mask_now();
    if (!wr_all_n)       return 4'hF;
    else if (!lane_wr_n) return ~lane_sel_n;
    else                 return 4'h0;
  endfunction

  task automatic compare_now();
    logic ez;
    ez = out_en_n || sleep || !m_drv || !m_sel;
    check(tag, "hiz", {35'd0, dout_hiz}, {35'd0, ez});
    check(tag, "data", dout, ez ? '0 : m_dat);
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    if (rst) begin
      m_sel = 0; m_drv = 0;
    end else begin
      m_drv = 0;
      if (m_sel && !sleep && m_mask == 4'h0) begin
        m_drv = 1; m_dat = ref_mem[m_addr];
      end
      if (m_sel && !sleep && m_mask != 4'h0)
        for (int i = 0; i < 4; i++)
          if (m_mask[i]) ref_mem[m_addr][9*i +: 9] = m_din[9*i +: 9];
      m_sel  = !sel0_n && sel1 && !sel2_n && !sleep;
      m_mask = mask_now();
      m_addr = addr;
      m_din  = din;
    end
    compare_now();
  endtask

  task automatic cyc(input logic [AW-1:0] a, input logic [W-1:0] d,
                     input logic wa_n, input logic lw_n,
                     input logic [3:0] ls_n, input logic [2:0] cs);
    addr = a; din = d; wr_all_n = wa_n; lane_wr_n = lw_n; lane_sel_n = ls_n;
    {sel0_n, sel1, sel2_n} = cs;
    tick();
  endtask

  task automatic rd(input logic [AW-1:0] a);
    cyc(a, '0, 1'b1, 1'b1, 4'hF, SEL);
  endtask

  task automatic idle();
    cyc('0, '0, 1'b1, 1'b1, 4'hF, 3'b110);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL R4 watchdog: actual hang expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [W-1:0] keep;
    // R1: reset state
    tag = "R1";
    repeat (3) tick();
    rst = 1'b0;
    idle();
    check("R1", "hiz after reset", {35'd0, dout_hiz}, 36'd1);

    // R2: global writes with all lane enables off
    tag = "R2";
    for (int a = 0; a < DEPTH; a++)
      cyc(a[AW-1:0], 36'h9A5C3E17B ^ (36'(a) * 36'h10F0E1D2), 1'b0, 1'b1, 4'hF, SEL);

    // R4: pipelined reads, data one edge after capture
    tag = "R4";
    for (int a = 0; a < DEPTH; a++) rd(a[AW-1:0]);
    rd(4'd3);
    rd(4'd4);
    check("R4", "latency", dout, ref_mem[3]);

    // R3: lane-masked writes and an inert byte-write cycle
    tag = "R3";
    keep = ref_mem[9];
    cyc(4'd2, 36'hFEDCBA987, 1'b1, 1'b0, 4'b1010, SEL);
    cyc(4'd7, 36'h123456789, 1'b1, 1'b0, 4'b0111, SEL);
    cyc(4'd9, 36'h0F0F0F0F0, 1'b1, 1'b1, 4'b0000, SEL);
    rd(4'd2); rd(4'd7); rd(4'd9); rd(4'd9);
    check("R3", "byte-write off leaves word", dout, keep);

    // R9: write then immediate read of the same address
    tag = "R9";
    cyc(4'd4, 36'hC0FFEE123, 1'b0, 1'b1, 4'hF, SEL);
    rd(4'd4);
    rd(4'd4);
    check("R9", "write then read", dout, 36'hC0FFEE123);

    // R5: every non-selecting combination blocks a write
    tag = "R5";
    keep = ref_mem[6];
    foreach (keep[i]) ;
    for (int c = 0; c < 8; c++)
      if (c[2:0] != SEL) cyc(4'd6, 36'h0, 1'b0, 1'b1, 4'hF, c[2:0]);
    rd(4'd6); rd(4'd6);
    check("R5", "deselected write ignored", dout, keep);

    // R6: read followed by a deselect never shows its data
    tag = "R6";
    rd(4'd1); idle();
    check("R6", "released after deselect", {35'd0, dout_hiz}, 36'd1);

    // R10: a write releases the bus
    tag = "R10";
    rd(4'd1);
    cyc(4'd8, 36'h55AA55AA5, 1'b0, 1'b1, 4'hF, SEL);
    rd(4'd8);
    check("R10", "released after write", {35'd0, dout_hiz}, 36'd1);
    rd(4'd8);

    // R7: asynchronous output enable
    tag = "R7";
    rd(4'd1); rd(4'd1);
    out_en_n = 1'b1; #1;
    check("R7", "oe high hiz", {35'd0, dout_hiz}, 36'd1);
    check("R7", "oe high data", dout, '0);
    out_en_n = 1'b0; #1;
    check("R7", "oe low data", dout, ref_mem[1]);

    // R8: sleep blocks access and releases at once
    tag = "R8";
    sleep = 1'b1; #1;
    check("R8", "sleep hiz", {35'd0, dout_hiz}, 36'd1);
    keep = ref_mem[10];
    cyc(4'd10, 36'h0, 1'b0, 1'b1, 4'hF, SEL);
    cyc(4'd10, 36'h1, 1'b0, 1'b1, 4'hF, SEL);
    sleep = 1'b0;
    rd(4'd10); rd(4'd10);
    check("R8", "no write in sleep", dout, keep);

    // Mixed traffic checked every clock against the model
    tag = "R4";
    for (int n = 0; n < 400; n++) begin
      int k;
      k = $urandom_range(0, 9);
      out_en_n = ($urandom_range(0, 9) == 0);
      sleep    = ($urandom_range(0, 14) == 0);
      case (k)
        0, 1, 2, 3: rd(4'($urandom_range(0, DEPTH-1)));
        4: cyc(4'($urandom_range(0, DEPTH-1)), {$urandom, 4'($urandom)}, 1'b0, 1'b1, 4'($urandom), SEL);
        5, 6: cyc(4'($urandom_range(0, DEPTH-1)), {$urandom, 4'($urandom)}, 1'b1, 1'($urandom), 4'($urandom), SEL);
        default: cyc(4'($urandom_range(0, DEPTH-1)), {$urandom, 4'($urandom)}, 1'($urandom), 1'($urandom), 4'($urandom), 3'($urandom));
      endcase
    end

    summary();
    $finish;
  end
endmodule